// File: doc/BRIEF.md
# SCL Clock Divider

This block derives the serial clock of a two-wire bus controller from the system clock. It cascades three programmable stages. A half-period counter forms an oscillator whose period is `2*(thp+1)` system cycles. A power-of-two prescaler and a `(mdiv+1)` divider follow it and produce a phase tick. A fixed ten-phase sequencer then turns the phase ticks into the SCL level. The bus sequencer uses the phase tick and the phase index to place SCL edges and SDA change points.

The resulting SCL frequency is `f_sys / (2*(thp+1)) / 2^ndiv / (mdiv+1) / 10`. Searching for the best divider values is left to software, and pad driving is left to the bus logic. New settings are picked up only at stage boundaries, so a change never produces a shortened pulse. Clearing the enable parks the block with SCL released high.

Top module: `scl_clk_div`

## Requirements
- R1: After reset with `en_i` low, `scl_o` is 1, `phase_tick_o` is 0 and `phase_idx_o` is 0.
- R2: With settings held steady, `phase_tick_o` is a one-cycle pulse that repeats every `2*(T+1) * 2^N * (M+1)` cycles, where T is the effective half-period count, N is the prescale exponent and M is the multiplier.
- R3: A `thp_i` value below 5 behaves exactly like 5. For example, `thp_i` = 2 or 0 gives a 12-cycle oscillator period.
- R4: The 3-bit prescale exponent N selects a divide by 2^N, from 1 (N=0) up to 128 (N=7).
- R5: `ctl_i` carries the multiplier M in bits 6:3 and the prescale exponent N in bits 2:0.
- R6: A new `thp_i` takes effect at the next oscillator period boundary. New N and M values take effect at the next phase tick boundary. The cycle in progress always finishes with the old values.
- R7: While `en_i` is low, all counters are cleared, `scl_o` is 1, `phase_tick_o` is 0 and `phase_idx_o` is 0. The settings follow the inputs directly. After `en_i` rises, the first tick comes one full phase later under the current inputs.
- R8: `phase_idx_o` advances 0,1,…,9,0 in the same cycle that `phase_tick_o` is high. `scl_o` is 1 in phases 0–4 and 0 in phases 5–9, so one SCL period spans ten phase ticks.
- R9: Reset loads the running settings with T=0x18, M=2 and N=0. If the block is enabled as reset releases, these defaults time the first oscillator period and the first phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low parks the divider |
| thp_i | input | 8 | Oscillator half-period count |
| ctl_i | input | 7 | Packed multiplier (6:3) and prescale exponent (2:0) |
| scl_o | output | 1 | SCL level, high when released |
| phase_tick_o | output | 1 | One-cycle pulse at each phase boundary |
| phase_idx_o | output | 4 | Current phase, 0 to 9 |

## Verification
The bench builds the block with its default widths: an 8-bit half-period field, a 3-bit prescale exponent, a 4-bit multiplier and ten phases. With these widths the floor of 5 makes the shortest oscillator period 12 cycles. That keeps the largest prescale of 128 (a 1536-cycle phase) and the largest multiplier of 16 inside a short run. The same widths let the bench reach both deferred-load boundaries, the oscillator edge and the phase edge, within a few dozen cycles. A behavioural model, fed the same inputs, predicts the level, tick and phase on every cycle, and directed interval measurements name each corner.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    localparam int THP_W   = 8;
    localparam int NDIV_W  = 3;
    localparam int MDIV_W  = 4;
    localparam int CTL_W   = NDIV_W + MDIV_W;
    localparam int PHASES  = 10;
    localparam int PH_W    = $clog2(PHASES);
    localparam int PCNT_W  = (1 << NDIV_W) - 1;

    localparam logic [THP_W-1:0]  THP_MIN  = 8'd5;
    localparam logic [THP_W-1:0]  THP_RST  = 8'h18;
    localparam logic [MDIV_W-1:0] MDIV_RST = 4'd2;
    localparam logic [NDIV_W-1:0] NDIV_RST = 3'd0;

    typedef struct packed {
        logic [MDIV_W-1:0] mdiv;
        logic [NDIV_W-1:0] ndiv;
    } post_cfg_t;

    function automatic logic [THP_W-1:0] thp_floor(input logic [THP_W-1:0] v);
        return (v < THP_MIN) ? THP_MIN : v;
    endfunction

    function automatic post_cfg_t ctl_unpack(input logic [CTL_W-1:0] c);
        post_cfg_t r;
        r.mdiv = c[CTL_W-1:NDIV_W];
        r.ndiv = c[NDIV_W-1:0];
        return r;
    endfunction

    function automatic logic [PCNT_W-1:0] pow2_last(input logic [NDIV_W-1:0] n);
        logic [PCNT_W:0] w;
        w = ({{PCNT_W{1'b0}}, 1'b1} << n) - 1'b1;
        return w[PCNT_W-1:0];
    endfunction

endpackage

// File: rtl/scl_osc_stage.sv
module scl_osc_stage
    import scl_div_pkg::*;
#(
    parameter int W = THP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] thp_i,
    output logic         osc_end_o
);

    logic [W-1:0] hcnt;
    logic [W-1:0] act_thp;
    logic         hsel;
    logic         half_done;

    assign half_done = (hcnt == act_thp);
    assign osc_end_o = en && hsel && half_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt    <= '0;
            hsel    <= 1'b0;
            act_thp <= W'(THP_RST);
        end else if (!en) begin
            hcnt    <= '0;
            hsel    <= 1'b0;
            act_thp <= W'(thp_floor(THP_W'(thp_i)));
        end else if (half_done) begin
            hcnt <= '0;
            hsel <= ~hsel;
            if (hsel) begin
                act_thp <= W'(thp_floor(THP_W'(thp_i)));
            end
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    property p_thp_floor;
        @(posedge clk) disable iff (rst) act_thp >= W'(THP_MIN);
    endproperty
    AST_THP_FLOOR: assert property (p_thp_floor); // R3

    property p_thp_hold;
        @(posedge clk) disable iff (rst) (en && !osc_end_o) |=> $stable(act_thp);
    endproperty
    AST_THP_HOLD: assert property (p_thp_hold); // R6

endmodule

// File: rtl/scl_post_div.sv
module scl_post_div
    import scl_div_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      osc_end_i,
    input  post_cfg_t cfg_i,
    output logic      ph_end_o
);

    logic [PCNT_W-1:0] pcnt;
    logic [MDIV_W-1:0] mcnt;
    post_cfg_t         act;
    logic              pre_last;
    logic              mul_last;

    assign pre_last = (pcnt == pow2_last(act.ndiv));
    assign mul_last = (mcnt == act.mdiv);
    assign ph_end_o = osc_end_i && pre_last && mul_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt     <= '0;
            mcnt     <= '0;
            act.mdiv <= MDIV_RST;
            act.ndiv <= NDIV_RST;
        end else if (!en) begin
            pcnt <= '0;
            mcnt <= '0;
            act  <= cfg_i;
        end else if (osc_end_i) begin
            if (pre_last) begin
                pcnt <= '0;
                if (mul_last) begin
                    mcnt <= '0;
                    act  <= cfg_i;
                end else begin
                    mcnt <= mcnt + 1'b1;
                end
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    property p_cfg_hold;
        @(posedge clk) disable iff (rst) (en && !ph_end_o) |=> $stable(act);
    endproperty
    AST_CFG_HOLD: assert property (p_cfg_hold); // R6

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_div_pkg::*;
#(
    parameter int N  = PHASES,
    parameter int PW = PH_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          ph_end_i,
    output logic          scl_o,
    output logic          tick_o,
    output logic [PW-1:0] ph_o
);

    localparam logic [PW-1:0] LAST = PW'(N - 1);
    localparam logic [PW-1:0] HALF = PW'(N / 2);

    logic [PW-1:0] ph;
    logic          tick_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ph     <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= ph_end_i;
            if (ph_end_i) begin
                ph <= (ph == LAST) ? '0 : ph + 1'b1;
            end
        end
    end

    assign scl_o  = (ph < HALF);
    assign tick_o = tick_q;
    assign ph_o   = ph;

    property p_phase_range;
        @(posedge clk) disable iff (rst) ph <= LAST;
    endproperty
    AST_PHASE_RANGE: assert property (p_phase_range); // R8

    property p_phase_step;
        @(posedge clk) disable iff (rst)
            tick_q |-> (ph == (($past(ph) == LAST) ? '0 : $past(ph) + 1'b1));
    endproperty
    AST_PHASE_STEP: assert property (p_phase_step); // R8

    property p_tick_single;
        @(posedge clk) disable iff (rst) tick_q |=> !tick_q;
    endproperty
    AST_TICK_SINGLE: assert property (p_tick_single); // R2

endmodule

// File: rtl/scl_clk_div.sv
module scl_clk_div
    import scl_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [THP_W-1:0]  thp_i,
    input  logic [CTL_W-1:0]  ctl_i,
    output logic              scl_o,
    output logic              phase_tick_o,
    output logic [PH_W-1:0]   phase_idx_o
);

    logic      osc_end;
    logic      ph_end;
    post_cfg_t post_cfg;

    assign post_cfg = ctl_unpack(ctl_i);

    scl_osc_stage #(.W(THP_W)) u_osc (
        .clk       (clk),
        .rst       (rst),
        .en        (en_i),
        .thp_i     (thp_i),
        .osc_end_o (osc_end)
    );

    scl_post_div u_post (
        .clk       (clk),
        .rst       (rst),
        .en        (en_i),
        .osc_end_i (osc_end),
        .cfg_i     (post_cfg),
        .ph_end_o  (ph_end)
    );

    scl_phase_seq #(.N(PHASES), .PW(PH_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .en       (en_i),
        .ph_end_i (ph_end),
        .scl_o    (scl_o),
        .tick_o   (phase_tick_o),
        .ph_o     (phase_idx_o)
    );

    property p_disabled_idle;
        @(posedge clk) disable iff (rst)
            !en_i |=> (scl_o && !phase_tick_o && (phase_idx_o == '0));
    endproperty
    AST_DISABLED_IDLE: assert property (p_disabled_idle); // R7

endmodule

// File: tb/tb_scl_clk_div.sv
module tb_scl_clk_div;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [7:0] thp = 8'd5;
    logic [6:0] ctl = 7'd0;
    logic       scl;
    logic       tick;
    logic [3:0] ph;

    scl_clk_div dut (
        .clk          (clk),
        .rst          (rst),
        .en_i         (en),
        .thp_i        (thp),
        .ctl_i        (ctl),
        .scl_o        (scl),
        .phase_tick_o (tick),
        .phase_idx_o  (ph)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    vectors     = 0;
    int    miscompares = 0;
    string cur_req     = "R1";

    // behavioural reference state
    int m_cyc, m_osc, m_ph, m_T, m_N, m_M;
    bit m_tick;
    bit model_live = 1'b0;

    function automatic int floor5(int v);
        return (v < 5) ? 5 : v;
    endfunction

    always @(posedge clk) begin
        model_live = 1'b1;
        if (rst) begin
            m_T = 24; m_N = 0; m_M = 2;
            m_cyc = 0; m_osc = 0; m_ph = 0; m_tick = 1'b0;
        end else if (!en) begin
            m_cyc = 0; m_osc = 0; m_ph = 0; m_tick = 1'b0;
            m_T = floor5(int'(thp));
            m_N = int'(ctl[2:0]);
            m_M = int'(ctl[6:3]);
        end else begin
            m_tick = 1'b0;
            if (m_cyc == 2 * m_T + 1) begin
                m_cyc = 0;
                m_T   = floor5(int'(thp));
                if (m_osc == (1 << m_N) * (m_M + 1) - 1) begin
                    m_osc  = 0;
                    m_tick = 1'b1;
                    m_ph   = (m_ph == 9) ? 0 : m_ph + 1;
                    m_N    = int'(ctl[2:0]);
                    m_M    = int'(ctl[6:3]);
                end else begin
                    m_osc++;
                end
            end else begin
                m_cyc++;
            end
        end
    end

    always @(negedge clk) begin
        if (model_live) begin
            vectors++;
            if (scl !== (m_ph < 5) || tick !== m_tick || ph !== m_ph[3:0]) begin
                miscompares++;
                $display("FAIL %s model: scl=%b tick=%b ph=%0d expected scl=%b tick=%b ph=%0d",
                         cur_req, scl, tick, ph, (m_ph < 5), m_tick, m_ph);
            end
        end
    end

    task automatic check_int(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic count_to_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick);
    endtask

    task automatic interval(output int n);
        int dummy;
        count_to_tick(dummy);
        count_to_tick(n);
    endtask

    task automatic settle_interval(output int n);
        int dummy;
        interval(dummy);
        count_to_tick(n);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                miscompares++;
                $display("FAIL %s watchdog: actual %0d cycles expected below %0d", cur_req, cyc, WATCHDOG);
                finish_run();
            end
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        cur_req = "R1";
        check_int("R1", "scl after reset", int'(scl), 1);
        check_int("R1", "tick after reset", int'(tick), 0);
        check_int("R1", "phase after reset", int'(ph), 0);
        repeat (20) @(negedge clk);

        // R9: enabled through reset release, defaults time the first phase
        cur_req = "R9";
        rst = 1'b1; en = 1'b1; thp = 8'd5; ctl = 7'd0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        count_to_tick(n);
        check_int("R9", "cycles to first tick with defaults", n, 74);

        cur_req = "R2";
        interval(n);
        check_int("R2", "tick interval thp5 n0 m0", n, 12);

        cur_req = "R8";
        while (scl !== 1'b1) @(negedge clk);
        while (scl !== 1'b0) @(negedge clk);
        check_int("R8", "phase at scl fall", int'(ph), 5);
        n = 0;
        while (scl !== 1'b1) begin @(negedge clk); n++; end
        while (scl !== 1'b0) begin @(negedge clk); n++; end
        check_int("R8", "scl period cycles", n, 120);

        cur_req = "R3";
        thp = 8'd2;
        settle_interval(n);
        check_int("R3", "thp 2 acts as 5", n, 12);
        thp = 8'd0;
        settle_interval(n);
        check_int("R3", "thp 0 acts as 5", n, 12);
        thp = 8'd6;
        settle_interval(n);
        check_int("R2", "tick interval thp6", n, 14);

        cur_req = "R4";
        thp = 8'd5; ctl = 7'd3;
        settle_interval(n);
        check_int("R4", "prescale 8", n, 96);
        ctl = 7'd7;
        settle_interval(n);
        check_int("R4", "prescale 128", n, 1536);

        cur_req = "R5";
        ctl = {4'd4, 3'd1};
        settle_interval(n);
        check_int("R5", "mdiv4 ndiv1 packing", n, 120);
        ctl = {4'd15, 3'd0};
        settle_interval(n);
        check_int("R5", "mdiv15 packing", n, 192);

        cur_req = "R6";
        ctl = 7'd0;
        settle_interval(n);
        check_int("R6", "baseline", n, 12);
        thp = 8'd20;
        count_to_tick(n);
        check_int("R6", "thp change defers to osc boundary", n, 12);
        count_to_tick(n);
        check_int("R6", "new thp after boundary", n, 42);
        thp = 8'd5; ctl = {4'd3, 3'd0};
        settle_interval(n);
        check_int("R6", "mdiv3 baseline", n, 48);
        ctl = 7'd0;
        count_to_tick(n);
        check_int("R6", "mdiv change defers to phase boundary", n, 48);
        count_to_tick(n);
        check_int("R6", "new mdiv after boundary", n, 12);

        cur_req = "R7";
        ctl = {4'd3, 3'd0};
        settle_interval(n);
        while (scl !== 1'b0) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check_int("R7", "scl released when disabled", int'(scl), 1);
        check_int("R7", "no tick when disabled", int'(tick), 0);
        check_int("R7", "phase cleared when disabled", int'(ph), 0);
        thp = 8'd7; ctl = 7'd0;
        repeat (10) @(negedge clk);
        check_int("R7", "scl still high", int'(scl), 1);
        en = 1'b1;
        count_to_tick(n);
        check_int("R7", "first tick after enable uses live inputs", n, 16);
        check_int("R8", "phase after first tick", int'(ph), 1);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule